// File: doc/BRIEF.md
# Command Data-Timeout Monitor

This block guards a memory-card host controller against a command sequence that never completes. A free-running prescaler divides the peripheral clock into a slow tick. While a sequence is open, a counter counts these ticks from zero. When the count reaches a programmable limit, the block enters its timeout error state. The nominal timeout is the clock period × limit × prescale ratio.

The sequence logic drives three strobes: start, end and abort. End and abort each close the sequence, clear the counter and stop it. Firmware reaches the block through a simple register port. Through this port it sets the limit and an interrupt enable, and it clears a sticky status flag by writing one to it. The flag is set on the error only while the enable is on. The interrupt output is the flag gated by the enable. Timing of the card's busy phase is outside this block; firmware watches it.

The prescaler is never resynchronised to a start, so the first tick after a start arrives with an arbitrary phase. A limit of zero raises the error as soon as the sequence opens.

Top module: `cmd_dto_monitor`

## Requirements
- R1: The prescaler runs from reset without pause and produces exactly one tick in every PRESCALE_DIV consecutive clocks (default 10000). A start never resets it, so over any run of N×PRESCALE_DIV clocks inside a sequence the counter advances by exactly N.
- R2: `tick_count` is 0 whenever no sequence is open. While a sequence is open and no error is present, it rises by exactly 1 for each prescaler tick.
- R3: A pulse on `seq_end` closes the sequence. From the next cycle, `seq_active` is 0 and `tick_count` is 0.
- R4: A pulse on `seq_abort` closes the sequence. From the next cycle, `seq_active` is 0 and `tick_count` is 0.
- R5: `tmo_err` is 1 exactly when a sequence is open and `tick_count` is greater than or equal to the limit.
- R6: After reset, the limit reads 0xFFFF, the enable reads 0 and the flag reads 0. The register addresses are: 0 = limit (all bits), 1 = enable (bit 0), 2 = status flag (bit 0), 3 = tick count (read-only, writes ignored).
- R7: With a limit of 0, `tmo_err` is 1 in the first cycle after a start has been accepted.
- R8: The status flag is set at a clock edge only if `tmo_err` and the enable are both 1 before that edge. Once set, it stays set until software clears it.
- R9: `tmo_irq` equals the status flag AND the enable.
- R10: Writing a word with bit 0 = 1 to address 2 clears the flag, unless the flag is being set in the same cycle. Writing bit 0 = 0 to address 2 leaves the flag unchanged.
- R11: If a start arrives in the same cycle as an end or an abort, the closing strobe wins and the block is left idle with the count at 0.
- R12: Once the error is reached, `tick_count` holds its value and never wraps. A new start clears it to 0 and counting begins again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| seq_start | input | 1 | Command sequence begins (one-cycle strobe) |
| seq_end | input | 1 | Command sequence completed (one-cycle strobe) |
| seq_abort | input | 1 | Command-off abort by software (one-cycle strobe) |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register write address |
| wr_data | input | CNT_W | Register write data |
| rd_addr | input | 2 | Register read address |
| rd_data | output | CNT_W | Register read data (combinational) |
| seq_active | output | 1 | A sequence is open |
| tick_count | output | CNT_W | Prescaler ticks counted in the open sequence |
| tmo_err | output | 1 | Timeout error state |
| tmo_irq | output | 1 | Timeout interrupt request |

## Verification
The monitor is driven with several patterns. In sequences that end before the limit, the count must return to zero without an error. In sequences that run past a small limit, the count must freeze, and the error must persist until an abort. A zero limit separates an immediate error from one that waits for the first tick. Running each pattern with the enable on and with it off shows whether the flag and interrupt follow the gating or only the error. Start pulses that collide with end or abort show which strobe takes priority. Starts placed at varied prescaler phases show that the tick is never resynchronised.

// File: rtl/cdt_pkg.sv
package cdt_pkg;

   // Register address codes of the firmware port
   typedef enum logic [1:0] {
      CDT_A_LIMIT = 2'd0,
      CDT_A_CTRL  = 2'd1,
      CDT_A_STAT  = 2'd2,
      CDT_A_COUNT = 2'd3
   } cdt_addr_e;

   // Bit positions inside the control and status words
   localparam int unsigned CDT_CTRL_EN_BIT   = 0;
   localparam int unsigned CDT_STAT_FLAG_BIT = 0;

   // Closing strobe decoded from end / abort
   typedef struct packed {
      logic open_req;
      logic close_req;
   } cdt_seq_cmd_t;

endpackage

// File: rtl/cdt_prescaler.sv
module cdt_prescaler #(
   parameter int unsigned DIV = 10000
) (
   input  logic clk,
   input  logic rst_n,
   output logic tick
);
   localparam int unsigned PW = (DIV > 1) ? $clog2(DIV) : 1;
   localparam logic [PW-1:0] LAST = PW'(DIV - 1);

   initial begin
      if (DIV < 1) $error("cdt_prescaler: DIV must be at least 1");
   end

   generate
      if (DIV == 1) begin : g_pass
         // every clock is a tick
         assign tick = 1'b1;
      end else begin : g_div
         logic [PW-1:0] phase_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               phase_q <= '0;
            end else if (phase_q == LAST) begin
               phase_q <= '0;
            end else begin
               phase_q <= phase_q + 1'b1;
            end
         end

         assign tick = (phase_q == LAST);
      end
   endgenerate

endmodule

// File: rtl/cdt_seq_counter.sv
module cdt_seq_counter
   import cdt_pkg::*;
#(
   parameter int unsigned CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             seq_start,
   input  logic             seq_end,
   input  logic             seq_abort,
   input  logic             tick,
   input  logic [CNT_W-1:0] limit,
   output logic             active,
   output logic [CNT_W-1:0] count,
   output logic             err
);
   localparam logic [CNT_W-1:0] CNT_MAX = '1;

   cdt_seq_cmd_t cmd;
   logic         active_q;
   logic [CNT_W-1:0] count_q;
   logic         reached;
   logic         advance;

   initial begin
      if (CNT_W < 1 || CNT_W > 32) $error("cdt_seq_counter: CNT_W out of range");
   end

   // closing strobes take priority over a simultaneous start
   always_comb begin
      cmd.close_req = seq_end | seq_abort;
      cmd.open_req  = seq_start & ~cmd.close_req;
   end

   // limit comparison; also holds if the limit is lowered mid-sequence
   assign reached = active_q && (count_q >= limit);

   // count a tick only while open, not in error, and never past the top
   assign advance = active_q && tick && !reached && (count_q != CNT_MAX);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active_q <= 1'b0;
      end else if (cmd.close_req) begin
         active_q <= 1'b0;
      end else if (cmd.open_req) begin
         active_q <= 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         count_q <= '0;
      end else if (cmd.close_req || cmd.open_req) begin
         count_q <= '0;
      end else if (advance) begin
         count_q <= count_q + 1'b1;
      end
   end

   assign active = active_q;
   assign count  = count_q;
   assign err    = reached;

endmodule

// File: rtl/cdt_regs.sv
module cdt_regs
   import cdt_pkg::*;
#(
   parameter int unsigned CNT_W       = 16,
   parameter logic [CNT_W-1:0] LIMIT_RESET = '1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [1:0]       wr_addr,
   input  logic [CNT_W-1:0] wr_data,
   input  logic [1:0]       rd_addr,
   input  logic             err,
   input  logic [CNT_W-1:0] count,
   output logic [CNT_W-1:0] limit,
   output logic             en,
   output logic             flag,
   output logic [CNT_W-1:0] rd_data
);
   cdt_addr_e wa;
   cdt_addr_e ra;
   logic      wr_limit;
   logic      wr_ctrl;
   logic      clr_flag;
   logic      set_flag;

   logic [CNT_W-1:0] limit_q;
   logic             en_q;
   logic             flag_q;

   assign wa = cdt_addr_e'(wr_addr);
   assign ra = cdt_addr_e'(rd_addr);

   assign wr_limit = wr_en && (wa == CDT_A_LIMIT);
   assign wr_ctrl  = wr_en && (wa == CDT_A_CTRL);
   assign clr_flag = wr_en && (wa == CDT_A_STAT) && wr_data[CDT_STAT_FLAG_BIT];
   assign set_flag = err && en_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         limit_q <= LIMIT_RESET;
      end else if (wr_limit) begin
         limit_q <= wr_data;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q <= 1'b0;
      end else if (wr_ctrl) begin
         en_q <= wr_data[CDT_CTRL_EN_BIT];
      end
   end

   // sticky flag: setting wins over a clear in the same cycle
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flag_q <= 1'b0;
      end else if (set_flag) begin
         flag_q <= 1'b1;
      end else if (clr_flag) begin
         flag_q <= 1'b0;
      end
   end

   always_comb begin
      rd_data = '0;
      unique case (ra)
         CDT_A_LIMIT: rd_data = limit_q;
         CDT_A_CTRL:  rd_data[CDT_CTRL_EN_BIT] = en_q;
         CDT_A_STAT:  rd_data[CDT_STAT_FLAG_BIT] = flag_q;
         CDT_A_COUNT: rd_data = count;
         default:     rd_data = '0;
      endcase
   end

   assign limit = limit_q;
   assign en    = en_q;
   assign flag  = flag_q;

endmodule

// File: rtl/cmd_dto_monitor.sv
module cmd_dto_monitor #(
   parameter int unsigned PRESCALE_DIV = 10000,
   parameter int unsigned CNT_W        = 16,
   parameter logic [CNT_W-1:0] LIMIT_RESET = '1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             seq_start,
   input  logic             seq_end,
   input  logic             seq_abort,
   input  logic             wr_en,
   input  logic [1:0]       wr_addr,
   input  logic [CNT_W-1:0] wr_data,
   input  logic [1:0]       rd_addr,
   output logic [CNT_W-1:0] rd_data,
   output logic             seq_active,
   output logic [CNT_W-1:0] tick_count,
   output logic             tmo_err,
   output logic             tmo_irq
);
   initial begin
      if (PRESCALE_DIV < 1) $error("cmd_dto_monitor: PRESCALE_DIV must be >= 1");
      if (CNT_W < 2 || CNT_W > 32) $error("cmd_dto_monitor: CNT_W must be 2..32");
   end

   logic             pre_tick;
   logic [CNT_W-1:0] limit_q;
   logic             irq_en;
   logic             tmo_flag;

   cdt_prescaler #(
      .DIV (PRESCALE_DIV)
   ) u_pre (
      .clk   (clk),
      .rst_n (rst_n),
      .tick  (pre_tick)
   );

   cdt_seq_counter #(
      .CNT_W (CNT_W)
   ) u_cnt (
      .clk       (clk),
      .rst_n     (rst_n),
      .seq_start (seq_start),
      .seq_end   (seq_end),
      .seq_abort (seq_abort),
      .tick      (pre_tick),
      .limit     (limit_q),
      .active    (seq_active),
      .count     (tick_count),
      .err       (tmo_err)
   );

   cdt_regs #(
      .CNT_W       (CNT_W),
      .LIMIT_RESET (LIMIT_RESET)
   ) u_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .wr_addr (wr_addr),
      .wr_data (wr_data),
      .rd_addr (rd_addr),
      .err     (tmo_err),
      .count   (tick_count),
      .limit   (limit_q),
      .en      (irq_en),
      .flag    (tmo_flag),
      .rd_data (rd_data)
   );

   assign tmo_irq = tmo_flag & irq_en;

endmodule

// File: rtl/cdt_checker.sv
module cdt_checker #(
   parameter int unsigned CNT_W = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic             seq_start,
   input logic             seq_end,
   input logic             seq_abort,
   input logic             wr_en,
   input logic [1:0]       wr_addr,
   input logic [CNT_W-1:0] wr_data,
   input logic             seq_active,
   input logic [CNT_W-1:0] tick_count,
   input logic             tmo_err,
   input logic [CNT_W-1:0] limit_q,
   input logic             irq_en,
   input logic             tmo_flag
);
   p_idle_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !seq_active |-> tick_count == '0);

   p_step_one_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!$stable(tick_count) && tick_count != '0) |-> tick_count == $past(tick_count) + 1'b1);

   p_end_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
      seq_end |=> (!seq_active && tick_count == '0));

   p_abort_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
      seq_abort |=> (!seq_active && tick_count == '0));

   p_err_at_limit_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (seq_active && tick_count == limit_q) |-> tmo_err);

   p_flag_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(tmo_flag) |-> ($past(irq_en) && $past(tmo_err)));

   p_flag_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (tmo_flag && !(wr_en && wr_addr == 2'd2 && wr_data[0])) |=> tmo_flag);

   p_conflict_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (seq_start && (seq_end || seq_abort)) |=> !seq_active);

   p_hold_at_err_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (tmo_err && !seq_start && !seq_end && !seq_abort) |=> $stable(tick_count));

endmodule

bind cmd_dto_monitor cdt_checker #(.CNT_W(CNT_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .seq_start  (seq_start),
   .seq_end    (seq_end),
   .seq_abort  (seq_abort),
   .wr_en      (wr_en),
   .wr_addr    (wr_addr),
   .wr_data    (wr_data),
   .seq_active (seq_active),
   .tick_count (tick_count),
   .tmo_err    (tmo_err),
   .limit_q    (limit_q),
   .irq_en     (irq_en),
   .tmo_flag   (tmo_flag)
);

// File: tb/cmd_dto_monitor_tb_top.sv
module cmd_dto_monitor_tb_top;
   localparam int DIV = 8;
   localparam int W   = 16;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic seq_start = 0, seq_end = 0, seq_abort = 0, wr_en = 0;
   logic [1:0] wr_addr = 0, rd_addr = 0;
   logic [W-1:0] wr_data = 0;
   logic [W-1:0] rd_data, tick_count;
   logic seq_active, tmo_err, tmo_irq;

   int checks = 0;
   int errors = 0;
   bit cmp_on = 0;
   bit done = 0;

   // reference model state
   int m_pre = 0, m_cnt = 0, m_lim = 16'hFFFF;
   bit m_act = 0, m_en = 0, m_flag = 0;

   always #10 clk = ~clk;

   cmd_dto_monitor #(.PRESCALE_DIV(DIV), .CNT_W(W)) dut_i (
      .clk(clk), .rst_n(rst_n), .seq_start(seq_start), .seq_end(seq_end),
      .seq_abort(seq_abort), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .rd_addr(rd_addr), .rd_data(rd_data), .seq_active(seq_active),
      .tick_count(tick_count), .tmo_err(tmo_err), .tmo_irq(tmo_irq));

   function automatic bit m_err();
      return m_act && (m_cnt >= m_lim);
   endfunction

   function automatic int m_rd(input int a);
      case (a)
         0: return m_lim;
         1: return int'(m_en);
         2: return int'(m_flag);
         default: return m_cnt;
      endcase
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         m_pre = 0; m_cnt = 0; m_lim = 16'hFFFF; m_act = 0; m_en = 0; m_flag = 0;
      end else begin
         bit tk, er;
         tk = (m_pre == DIV - 1);
         er = m_err();
         m_pre = tk ? 0 : m_pre + 1;
         if (er && m_en) m_flag = 1;
         else if (wr_en && wr_addr == 2 && wr_data[0]) m_flag = 0;
         if (seq_end || seq_abort) begin m_act = 0; m_cnt = 0; end
         else if (seq_start) begin m_act = 1; m_cnt = 0; end
         else if (m_act && tk && !er && m_cnt < 16'hFFFF) m_cnt = m_cnt + 1;
         if (wr_en && wr_addr == 0) m_lim = int'(wr_data);
         if (wr_en && wr_addr == 1) m_en = wr_data[0];
      end
   end

   task automatic chk(input string req, input string what, input int got, input int exp);
      checks++;
      if (got != exp) begin
         errors++;
         $display("FAIL %s %s got %0d expected %0d at %0t", req, what, got, exp, $time);
      end
   endtask

   // per-cycle comparison against the model
   always @(negedge clk) begin
      if (cmp_on) begin
         chk("R2", "tick_count", int'(tick_count), m_cnt);
         chk("R3", "seq_active", int'(seq_active), int'(m_act));
         chk("R5", "tmo_err", int'(tmo_err), int'(m_err()));
         chk("R9", "tmo_irq", int'(tmo_irq), int'(m_flag && m_en));
         chk("R10", "rd_data", int'(rd_data), m_rd(int'(rd_addr)));
      end
   end

   task automatic cyc(input int n);
      repeat (n) @(posedge clk);
      #5;
   endtask

   task automatic wr(input int a, input int d);
      wr_en = 1; wr_addr = 2'(a); wr_data = W'(d);
      cyc(1);
      wr_en = 0;
   endtask

   task automatic strobe(input bit s, input bit e, input bit ab);
      seq_start = s; seq_end = e; seq_abort = ab;
      cyc(1);
      seq_start = 0; seq_end = 0; seq_abort = 0;
   endtask

   task automatic finish_up();
      if (!done) begin
         done = 1;
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   endtask

   initial begin
      #(20 * 100000);
      errors++;
      $display("FAIL watchdog expired got 0 expected 1");
      finish_up();
   end

   initial begin
      cyc(3);
      rst_n = 1;
      cyc(1);
      cmp_on = 1;
      // R6: reset values
      rd_addr = 0; #1 chk("R6", "limit reset", int'(rd_data), 16'hFFFF);
      rd_addr = 1; #1 chk("R6", "enable reset", int'(rd_data), 0);
      rd_addr = 2; #1 chk("R6", "flag reset", int'(rd_data), 0);
      rd_addr = 3;

      // R1: exactly 4 ticks in 4*DIV cycles, at several phases
      for (int ph = 0; ph < 3; ph++) begin
         cyc(ph + 1);
         strobe(1, 0, 0);
         cyc(4 * DIV - 1);
         chk("R1", "ticks in 4 periods", int'(tick_count), 4);
         strobe(0, 1, 0);
         // R3: end clears
         chk("R3", "count after end", int'(tick_count), 0);
         chk("R3", "active after end", int'(seq_active), 0);
      end

      // R8 gating off: limit 0, enable 0
      wr(0, 0);
      strobe(1, 0, 0);
      // R7: immediate error
      chk("R7", "err with zero limit", int'(tmo_err), 1);
      cyc(3);
      rd_addr = 2; #1 chk("R8", "flag with enable off", int'(rd_data), 0);
      chk("R9", "irq with enable off", int'(tmo_irq), 0);
      // R4: abort clears
      strobe(0, 0, 1);
      chk("R4", "active after abort", int'(seq_active), 0);
      chk("R4", "count after abort", int'(tick_count), 0);
      chk("R4", "err after abort", int'(tmo_err), 0);

      // enable on, limit 2, run past limit: R12 hold
      wr(1, 1);
      wr(0, 2);
      rd_addr = 3;
      strobe(1, 0, 0);
      cyc(10 * DIV);
      chk("R12", "count holds at limit", int'(tick_count), 2);
      chk("R5", "err at limit", int'(tmo_err), 1);
      chk("R9", "irq raised", int'(tmo_irq), 1);
      // R12: restart from zero
      strobe(1, 0, 0);
      chk("R12", "restart count", int'(tick_count), 0);
      chk("R5", "no err after restart", int'(tmo_err), 0);
      strobe(0, 0, 1);

      // R10: writing 0 keeps flag, writing 1 clears
      rd_addr = 2;
      wr(2, 0);
      chk("R10", "flag after write 0", int'(rd_data), 1);
      wr(2, 1);
      chk("R10", "flag after write 1", int'(rd_data), 0);
      chk("R9", "irq after clear", int'(tmo_irq), 0);
      // address 3 write ignored
      wr(3, 16'h1234);
      rd_addr = 3; #1 chk("R6", "count not writable", int'(rd_data), 0);

      // R11: start with end, start with abort
      strobe(1, 1, 0);
      chk("R11", "start+end idle", int'(seq_active), 0);
      strobe(1, 0, 1);
      chk("R11", "start+abort idle", int'(seq_active), 0);
      chk("R11", "count cleared", int'(tick_count), 0);

      // sequence ending before limit: no error, no flag
      wr(0, 5);
      strobe(1, 0, 0);
      cyc(2 * DIV);
      strobe(0, 1, 0);
      rd_addr = 2; #1 chk("R8", "no flag on early end", int'(rd_data), 0);
      cyc(4);
      finish_up();
   end
endmodule